// File: doc/BRIEF.md
# Timer Event Edge Capture Unit

This block samples a free-running timer value at the moment a chosen transition appears on an external event pin. The pin is asynchronous to the block clock. It passes through a synchronizer first, and then an edge detector qualifies each transition against a two-bit edge selection. Each qualifying event copies the counter value presented on `count_i` into a capture register and raises a capture flag.

There are two capture sequences. In single mode, the first qualifying event is stored in the first capture register. In double mode, the first event is stored in the first register and the next event is stored in the second register, so software can measure the distance between two transitions. Once the sequence has finished, the unit ignores further edges until software writes the clear strobe. That strobe drops the flag and starts the sequence again. When the edge selection moves from disabled to any enabled value, the flag and the edge history are cleared, so an old transition cannot cause a capture.

The counter itself and the register decoding are outside this block. Software can only read the capture registers. The only thing it can write here is the flag clear strobe.

Top module: `evt_capture_unit`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it falls, `cap1_o`, `cap2_o` and `cap_flag_o` are all 0.
- R2: With `edge_mode_i` = 2'b00, no transition on `evt_pin_i` changes `cap1_o`, `cap2_o` or `cap_flag_o`.
- R3: With `edge_mode_i` = 2'b01, only low-to-high transitions of `evt_pin_i` are qualifying events.
- R4: With `edge_mode_i` = 2'b10, only high-to-low transitions of `evt_pin_i` are qualifying events.
- R5: With `edge_mode_i` = 2'b11, transitions in either direction are qualifying events.
- R6: A pin change that is applied before clock edge k is seen by the edge detector after edge k+1. The register then loads the `count_i` value present between edges k+1 and k+2, and that value appears on the output after edge k+2.
- R7: With `second_mode_i` = 0, the first qualifying event loads `cap1_o`. `cap2_o` is left unchanged, and later events are ignored until the flag is cleared.
- R8: With `second_mode_i` = 1, the first qualifying event loads `cap1_o` and the next one loads `cap2_o`. After that, events are ignored until the flag is cleared. Events that arrive while the unit waits for the second capture with `second_mode_i` at 0 are ignored.
- R9: A cycle with `flag_clr_i` = 1 clears `cap_flag_o` on the next edge and restarts the sequence at the first capture. The clear wins over an event in the same cycle, and that event is dropped.
- R10: In the cycle where `edge_mode_i` first leaves 2'b00, the flag is cleared, the sequence restarts, and any transition seen in that cycle is dropped.
- R11: Each capture sets `cap_flag_o` in the same edge that loads the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_pin_i | input | 1 | Asynchronous external event pin |
| count_i | input | CNT_W | Current timer counter value |
| edge_mode_i | input | 2 | 00 off, 01 rising, 10 falling, 11 both |
| second_mode_i | input | 1 | 0 single capture, 1 first plus second capture |
| flag_clr_i | input | 1 | Write-1-to-clear strobe for the capture flag |
| cap1_o | output | CNT_W | First capture register |
| cap2_o | output | CNT_W | Second capture register |
| cap_flag_o | output | 1 | Capture interrupt flag |

## Verification
The hardest conditions to reach from the ports are coincidences. One is a synchronized transition landing on the exact cycle in which detection is switched on from the disabled state. The other is an event meeting a clear strobe in the same cycle. The stimulus schedules pin changes two cycles ahead of the mode write, counting the synchronizer stages, so that the edge arrives in the arming cycle. Random phases then mix clear strobes, mode switches and sequence-mode flips so that they often collide with qualifying transitions.

// File: rtl/evt_capture_pkg.sv
package evt_capture_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    SEQ_FIRST  = 2'b00,
    SEQ_SECOND = 2'b01,
    SEQ_DONE   = 2'b10
  } seq_state_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= '0;
    else       chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/evt_edge_detect.sv
module evt_edge_detect
  import evt_capture_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      sync_i,
  input  edge_sel_e mode_i,
  output logic      hit_o,
  output logic      arm_o
);
  logic      prev_q;
  edge_sel_e mode_q;
  logic      rise, fall, sel;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q <= 1'b0;
      mode_q <= EDGE_OFF;
    end else begin
      prev_q <= sync_i;
      mode_q <= mode_i;
    end
  end

  always_comb begin
    rise  = sync_i & ~prev_q;
    fall  = ~sync_i & prev_q;
    arm_o = (mode_q == EDGE_OFF) && (mode_i != EDGE_OFF);
    unique case (mode_i)
      EDGE_RISE: sel = rise;
      EDGE_FALL: sel = fall;
      EDGE_ANY:  sel = rise | fall;
      default:   sel = 1'b0;
    endcase
    hit_o = sel & ~arm_o;
  end
endmodule

// File: rtl/evt_capture_seq.sv
module evt_capture_seq
  import evt_capture_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             hit_i,
  input  logic             arm_i,
  input  logic             clr_i,
  input  logic             second_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap1_o,
  output logic [CNT_W-1:0] cap2_o,
  output logic             flag_o
);
  seq_state_e seq_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      seq_q  <= SEQ_FIRST;
      cap1_o <= '0;
      cap2_o <= '0;
      flag_o <= 1'b0;
    end else if (clr_i || arm_i) begin
      seq_q  <= SEQ_FIRST;
      flag_o <= 1'b0;
    end else if (hit_i) begin
      unique case (seq_q)
        SEQ_FIRST: begin
          cap1_o <= count_i;
          flag_o <= 1'b1;
          seq_q  <= second_i ? SEQ_SECOND : SEQ_DONE;
        end
        SEQ_SECOND: begin
          if (second_i) begin
            cap2_o <= count_i;
            flag_o <= 1'b1;
            seq_q  <= SEQ_DONE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evt_capture_unit.sv
module evt_capture_unit
  import evt_capture_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             evt_pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       edge_mode_i,
  input  logic             second_mode_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap1_o,
  output logic [CNT_W-1:0] cap2_o,
  output logic             cap_flag_o
);
  logic pin_sync, hit, arm;

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .async_i(evt_pin_i),
    .sync_o (pin_sync)
  );

  evt_edge_detect u_edge (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .sync_i(pin_sync),
    .mode_i(edge_sel_e'(edge_mode_i)),
    .hit_o (hit),
    .arm_o (arm)
  );

  evt_capture_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .hit_i   (hit),
    .arm_i   (arm),
    .clr_i   (flag_clr_i),
    .second_i(second_mode_i),
    .count_i (count_i),
    .cap1_o  (cap1_o),
    .cap2_o  (cap2_o),
    .flag_o  (cap_flag_o)
  );
endmodule

// File: rtl/evt_capture_checker.sv
module evt_capture_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [1:0]       edge_mode_i,
  input logic             second_mode_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] cap1_o,
  input logic [CNT_W-1:0] cap2_o,
  input logic             cap_flag_o
);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (edge_mode_i == 2'b00) |=> ($stable(cap1_o) && $stable(cap2_o) && !$rose(cap_flag_o)));

  p_single_slot_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !(!$stable(cap1_o) && !$stable(cap2_o)));

  p_second_needs_mode_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(cap2_o) |-> $past(second_mode_i));

  p_clear_drops_flag_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    flag_clr_i |=> !cap_flag_o);

  p_arm_clears_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(edge_mode_i) == 2'b00 && edge_mode_i != 2'b00) |=> !cap_flag_o);

  p_capture_flags_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(cap1_o) || !$stable(cap2_o)) |-> cap_flag_o);
endmodule

bind evt_capture_unit evt_capture_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .edge_mode_i  (edge_mode_i),
  .second_mode_i(second_mode_i),
  .flag_clr_i   (flag_clr_i),
  .cap1_o       (cap1_o),
  .cap2_o       (cap2_o),
  .cap_flag_o   (cap_flag_o)
);

// File: tb/evt_capture_unit_test.sv
module evt_capture_unit_test;
  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rst;
  logic             pin;
  logic [CNT_W-1:0] count;
  logic [1:0]       mode;
  logic             second;
  logic             clr;
  logic [CNT_W-1:0] cap1, cap2;
  logic             flag;

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R1";
  bit    finished = 1'b0;

  always #4 clk = ~clk;

  evt_capture_unit #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_i(rst), .evt_pin_i(pin), .count_i(count),
    .edge_mode_i(mode), .second_mode_i(second), .flag_clr_i(clr),
    .cap1_o(cap1), .cap2_o(cap2), .cap_flag_o(flag)
  );

  // Expected behaviour derived from the requirements, one step per clock edge.
  logic             m_s1, m_s2, m_prev, m_flag;
  logic [1:0]       m_modeq, m_seq;
  logic [CNT_W-1:0] m_c1, m_c2;

  always @(posedge clk) begin : model
    logic arm, rise, fall, hit;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_flag = 0;
      m_modeq = 0; m_seq = 0; m_c1 = '0; m_c2 = '0;
    end else begin
      arm  = (m_modeq == 2'b00) && (mode != 2'b00);
      rise = m_s2 && !m_prev;
      fall = !m_s2 && m_prev;
      hit  = !arm && ((mode == 2'b01 && rise) || (mode == 2'b10 && fall) ||
                      (mode == 2'b11 && (rise || fall)));
      if (clr || arm) begin
        m_flag = 0; m_seq = 0;
      end else if (hit) begin
        if (m_seq == 0) begin
          m_c1 = count; m_flag = 1; m_seq = second ? 2'd1 : 2'd2;
        end else if (m_seq == 1 && second) begin
          m_c2 = count; m_flag = 1; m_seq = 2'd2;
        end
      end
      m_prev  = m_s2;
      m_s2    = m_s1;
      m_s1    = pin;
      m_modeq = mode;
    end
  end

  task automatic check_outputs();
    n_checks++;
    if (cap1 !== m_c1) begin
      n_fail++;
      $display("FAIL %s cap1 actual=%h expected=%h", tag, cap1, m_c1);
    end
    n_checks++;
    if (cap2 !== m_c2) begin
      n_fail++;
      $display("FAIL %s cap2 actual=%h expected=%h", tag, cap2, m_c2);
    end
    n_checks++;
    if (flag !== m_flag) begin
      n_fail++;
      $display("FAIL %s flag actual=%0b expected=%0b", tag, flag, m_flag);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_outputs();
      count = count + 32'd1;
      clr   = 1'b0;
    end
  endtask

  task automatic pulse_clear();
    clr = 1'b1;
    tick(1);
  endtask

  task automatic edge_train(input int n);
    for (int i = 0; i < n; i++) begin
      pin = ~pin;
      tick(4);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired in %s", tag);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; pin = 0; count = 32'h1000_0000; mode = 2'b00; second = 0; clr = 0;
    tag = "R1";
    tick(3);
    rst = 0;
    tick(2);

    tag = "R2";
    edge_train(6);

    tag = "R3";
    mode = 2'b01; tick(2);
    edge_train(3);
    pulse_clear(); edge_train(4);

    tag = "R4";
    mode = 2'b00; tick(2); mode = 2'b10; tick(2);
    edge_train(3);
    pulse_clear(); edge_train(4);

    tag = "R5";
    mode = 2'b00; tick(2); mode = 2'b11; tick(2);
    pulse_clear(); edge_train(3);

    tag = "R6";
    pulse_clear(); pin = ~pin; tick(1); count = 32'hDEAD_BEEF; tick(5);

    tag = "R7";
    second = 0; pulse_clear(); edge_train(5);

    tag = "R8";
    second = 1; pulse_clear(); edge_train(5);
    pulse_clear(); pin = ~pin; tick(4); second = 0; edge_train(3);
    second = 1; edge_train(2);

    tag = "R9";
    pulse_clear(); pin = ~pin; tick(2); clr = 1; tick(1); tick(3);
    edge_train(2);

    tag = "R10";
    mode = 2'b00; tick(3);
    pin = ~pin; tick(2); mode = 2'b11; tick(4);
    edge_train(2);
    mode = 2'b00; tick(2);
    pin = ~pin; tick(1); mode = 2'b01; tick(4);

    tag = "R11";
    second = 1; mode = 2'b11; pulse_clear(); edge_train(3);

    tag = "R3/R4/R5/R8/R9 random";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) pin = ~pin;
      if ($urandom_range(0, 60) == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 40) == 0) second = ~second;
      if ($urandom_range(0, 15) == 0) clr = 1'b1;
      if ($urandom_range(0, 200) == 0) count = $urandom;
      tick(1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule